// File: doc/BRIEF.md
# Sparse Multiply-Accumulate Processing Element

This block is one processing element of a sparse matrix-vector engine. A central scanner broadcasts only the non-zero input activations, each tagged with its column index, to every element. The element stores these in a small backlog queue so that a slow column on this element does not immediately stall the broadcaster. The activation at the head of the queue is the one being worked on. The element shows that activation's column index to its weight fetch logic and accepts the matching stream of compressed weight entries.

Each weight entry carries a 4-bit shared-weight code and a 4-bit relative row offset. The code selects a signed 16-bit value from a 16-entry codebook, which is loaded through a write port. The offset counts the rows skipped since the previous entry of the same column. A running row counter turns the offsets into absolute rows, and the element adds weight × activation into a bank of 64 signed 32-bit accumulators. An end-of-column flag on the last entry retires the head activation and restarts the row count. Accumulators are read through a combinational read port and cleared synchronously.

Control is a two-state machine. In Idle the queue is empty or has just been written. In Run the element accepts entries. Transition START (Idle→Run) fires on the first clock edge that sees a non-empty queue. NEXT keeps the machine in Run, either within a column or when a last entry retires an activation while another remains queued. FINISH (Run→Idle) fires when a last entry retires the only queued activation and no new one arrives in that cycle.

Top module: `spmac_pe`

## Requirements
- R1: A codebook write (`cb_we`=1) stores `cb_wdata` (signed 16-bit) at `cb_addr`. From the next cycle on, any entry whose `ent_code` equals that address uses this value as its weight.
- R2: The activation queue holds 8 activations. `act_full` is 1 exactly when 8 are held. An activation offered while `act_full` is 1 is dropped and never processed.
- R3: Activations are processed in arrival order. `ent_ready` is 1 only in Run, and while it is 1, `cur_col` equals the column index of the activation being processed.
- R4: Each accepted entry (`ent_valid` and `ent_ready` both 1) adds codebook[`ent_code`] × activation value, a signed 32-bit product, to the accumulator of its row. The sum wraps modulo 2^32.
- R5: The first entry of a column targets row `ent_rel`. Every later entry targets the previous entry's row + 1 + `ent_rel`.
- R6: An accepted entry with `ent_last`=1 retires the current activation. The next activation's rows count again from row 0.
- R7: An entry whose computed row is 64 or more changes no accumulator. Every later entry of the same column also changes none.
- R8: `acc_clear`=1 zeroes all 64 accumulators at the next edge. It takes precedence over an entry accepted in the same cycle.
- R9: After reset the queue is empty, `act_full` and `ent_ready` are 0, every accumulator reads 0, and every codebook entry is 0.
- R10: START: from Idle with a non-empty queue, the machine enters Run at the next edge, so `ent_ready` rises one cycle after the push edge. FINISH: after the last queued activation retires, `ent_ready` is 0 from the next edge.
- R11: An entry whose code decodes to weight 0 adds nothing but still advances the row counter as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cb_we | input | 1 | Codebook write enable |
| cb_addr | input | 4 | Codebook write address (shared-weight code) |
| cb_wdata | input | 16 | Signed weight value to store |
| act_valid | input | 1 | Broadcast activation present |
| act_value | input | 16 | Signed non-zero activation value |
| act_col | input | 8 | Column index of the activation |
| act_full | output | 1 | Queue full; broadcaster must hold |
| ent_valid | input | 1 | Weight entry present |
| ent_code | input | 4 | Shared-weight code of the entry |
| ent_rel | input | 4 | Rows skipped since previous entry |
| ent_last | input | 1 | Final entry of this column slice |
| ent_ready | output | 1 | Element accepts entries (Run state) |
| cur_col | output | 8 | Column index of the activation in process |
| acc_clear | input | 1 | Synchronous clear of all accumulators |
| rd_row | input | 6 | Accumulator read row |
| rd_data | output | 32 | Signed accumulator value of `rd_row` |

## Verification
A wrong row counter does not corrupt just one value. Every later entry of that column lands in a shifted row, so the fault shows as a whole misplaced set of sums at the next readback of the accumulator bank. A queue pointer or count error shows within one column: `cur_col` names the wrong activation when `ent_ready` rises, or `act_full` toggles at a count other than 8. Codebook, clear-priority and state-transition faults show one edge after the stimulus, through `rd_data` and `ent_ready`. The bench therefore checks `cur_col` at the start of every column and reads all 64 rows after each phase.

// File: rtl/spmac_pkg.sv
package spmac_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } pe_state_t;

endpackage

// File: rtl/spmac_actq.sv
module spmac_actq #(
    parameter int DEPTH = 8,
    parameter int W     = 24
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic                         full,
    output logic                         empty,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  slot_q [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          push_ok, pop_ok;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = slot_q[rd_q];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (push_ok) begin
            slot_q[wr_q] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) begin
                wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
            end
            if (pop_ok) begin
                rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
            end
            unique case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R2: occupancy never exceeds the queue depth
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    // R2: an offer to a full queue without a pop leaves the occupancy unchanged
    p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop_ok) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/spmac_codebook.sv
module spmac_codebook #(
    parameter int ENTRIES = 16,
    parameter int WGT_W   = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               we,
    input  logic [$clog2(ENTRIES)-1:0]         waddr,
    input  logic signed [WGT_W-1:0]            wdata,
    input  logic [$clog2(ENTRIES)-1:0]         raddr,
    output logic signed [WGT_W-1:0]            rdata
);
    localparam int AW = $clog2(ENTRIES);

    logic signed [WGT_W-1:0] wgt_q [ENTRIES];

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    wgt_q[g] <= '0;
                end else if (we && (waddr == AW'(g))) begin
                    wgt_q[g] <= wdata;
                end
            end
        end
    endgenerate

    assign rdata = wgt_q[raddr];

    // R1: a written value is held at its address one edge later
    p_cb_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (wgt_q[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/spmac_rowgen.sv
module spmac_rowgen #(
    parameter int ROWS  = 64,
    parameter int REL_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        step,
    input  logic                        last,
    input  logic [REL_W-1:0]            rel,
    output logic [$clog2(ROWS)-1:0]     row,
    output logic                        row_ok
);
    localparam int ROW_W = $clog2(ROWS);
    localparam int BW    = $clog2(ROWS + 1);
    localparam int SW    = ((BW > REL_W) ? BW : REL_W) + 2;

    logic [BW-1:0] base_q;
    logic [SW-1:0] sum, sum_next;

    assign sum      = SW'(base_q) + SW'(rel);
    assign sum_next = sum + SW'(1);
    assign row_ok   = (sum < SW'(ROWS));
    assign row      = sum[ROW_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (step) begin
            if (last) begin
                base_q <= '0;
            end else if (sum_next >= SW'(ROWS)) begin
                base_q <= BW'(ROWS);
            end else begin
                base_q <= BW'(sum_next);
            end
        end
    end

    // R6: the row count restarts after an end-of-column entry
    p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last) |=> (base_q == '0));

    // R7: once a column runs past the bank, it stays past the bank
    p_stay_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !last && !row_ok) |=> !row_ok);

    // R5: the next base sits one above the row just used
    p_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !last && row_ok && (row != ROW_W'(ROWS - 1)))
            |=> (SW'(base_q) == SW'($past(row)) + SW'(1)));

endmodule

// File: rtl/spmac_accbank.sv
module spmac_accbank #(
    parameter int ROWS  = 64,
    parameter int ACC_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear,
    input  logic                        add_en,
    input  logic [$clog2(ROWS)-1:0]     add_row,
    input  logic signed [ACC_W-1:0]     add_val,
    input  logic [$clog2(ROWS)-1:0]     rd_row,
    output logic signed [ACC_W-1:0]     rd_data
);
    localparam int ROW_W = $clog2(ROWS);

    logic signed [ACC_W-1:0] acc_q [ROWS];
    logic                    any_set;

    generate
        for (genvar g = 0; g < ROWS; g++) begin : g_row
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    acc_q[g] <= '0;
                end else if (clear) begin
                    acc_q[g] <= '0;
                end else if (add_en && (add_row == ROW_W'(g))) begin
                    acc_q[g] <= acc_q[g] + add_val;
                end
            end
        end
    endgenerate

    assign rd_data = acc_q[rd_row];

    always_comb begin
        any_set = 1'b0;
        for (int i = 0; i < ROWS; i++) begin
            any_set = any_set | (|acc_q[i]);
        end
    end

    // R8: a clear leaves every accumulator at zero
    p_clear_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !any_set);

    // R4: an add without clear moves the target row by exactly the addend
    p_add_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && !clear)
            |=> (acc_q[$past(add_row)] == $past(acc_q[add_row]) + $past(add_val)));

endmodule

// File: rtl/spmac_pe.sv
module spmac_pe
    import spmac_pkg::*;
#(
    parameter int ROWS     = 64,
    parameter int QDEPTH   = 8,
    parameter int CB_SIZE  = 16,
    parameter int WGT_W    = 16,
    parameter int ACT_W    = 16,
    parameter int COL_W    = 8,
    parameter int REL_W    = 4,
    parameter int ACC_W    = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cb_we,
    input  logic [$clog2(CB_SIZE)-1:0]         cb_addr,
    input  logic [WGT_W-1:0]                   cb_wdata,
    input  logic                               act_valid,
    input  logic [ACT_W-1:0]                   act_value,
    input  logic [COL_W-1:0]                   act_col,
    output logic                               act_full,
    input  logic                               ent_valid,
    input  logic [$clog2(CB_SIZE)-1:0]         ent_code,
    input  logic [REL_W-1:0]                   ent_rel,
    input  logic                               ent_last,
    output logic                               ent_ready,
    output logic [COL_W-1:0]                   cur_col,
    input  logic                               acc_clear,
    input  logic [$clog2(ROWS)-1:0]            rd_row,
    output logic [ACC_W-1:0]                   rd_data
);
    localparam int ROW_W  = $clog2(ROWS);
    localparam int QW     = ACT_W + COL_W;
    localparam int CNT_W  = $clog2(QDEPTH + 1);
    localparam int PROD_W = WGT_W + ACT_W;

    pe_state_t               state_q, state_d;
    logic [QW-1:0]           head;
    logic                    q_empty, q_full;
    logic [CNT_W-1:0]        q_count;
    logic                    push_ok, step, retire;
    logic signed [WGT_W-1:0] wgt;
    logic signed [ACT_W-1:0] head_val;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0] addend;
    logic [ROW_W-1:0]        tgt_row;
    logic                    tgt_ok;
    logic signed [ACC_W-1:0] rd_val;

    assign push_ok  = act_valid && !q_full;
    assign step     = ent_valid && ent_ready;
    assign retire   = step && ent_last;
    assign head_val = head[QW-1:COL_W];

    spmac_actq #(.DEPTH(QDEPTH), .W(QW)) u_actq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (act_valid),
        .din   ({act_value, act_col}),
        .pop   (retire),
        .dout  (head),
        .full  (q_full),
        .empty (q_empty),
        .count (q_count)
    );

    spmac_codebook #(.ENTRIES(CB_SIZE), .WGT_W(WGT_W)) u_cb (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cb_we),
        .waddr (cb_addr),
        .wdata (cb_wdata),
        .raddr (ent_code),
        .rdata (wgt)
    );

    spmac_rowgen #(.ROWS(ROWS), .REL_W(REL_W)) u_rowgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .last   (ent_last),
        .rel    (ent_rel),
        .row    (tgt_row),
        .row_ok (tgt_ok)
    );

    assign prod   = wgt * head_val;
    assign addend = ACC_W'(prod);

    spmac_accbank #(.ROWS(ROWS), .ACC_W(ACC_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (acc_clear),
        .add_en  (step && tgt_ok),
        .add_row (tgt_row),
        .add_val (addend),
        .rd_row  (rd_row),
        .rd_data (rd_val)
    );

    assign rd_data = rd_val;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: START, NEXT, FINISH
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!q_empty) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (retire && (q_count == CNT_W'(1)) && !push_ok) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ent_ready = 1'b0;
        cur_col   = '0;
        unique case (state_q)
            ST_IDLE: begin
                ent_ready = 1'b0;
            end
            ST_RUN: begin
                ent_ready = 1'b1;
                cur_col   = head[COL_W-1:0];
            end
            default: ent_ready = 1'b0;
        endcase
        act_full = q_full;
    end

    // R3: entries are only taken while an activation is queued
    p_ready_has_act_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ent_ready |-> !q_empty);

    // R10: START fires one edge after the queue becomes non-empty in Idle
    p_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && !q_empty) |=> (state_q == ST_RUN));

    // R2: a full queue is reported at the port
    p_full_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == CNT_W'(QDEPTH)) |-> act_full);

endmodule

// File: tb/spmac_pe_bench.sv
module spmac_pe_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ROWS = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cb_we = 1'b0;
    logic [3:0]  cb_addr = '0;
    logic [15:0] cb_wdata = '0;
    logic        act_valid = 1'b0;
    logic [15:0] act_value = '0;
    logic [7:0]  act_col = '0;
    logic        act_full;
    logic        ent_valid = 1'b0;
    logic [3:0]  ent_code = '0;
    logic [3:0]  ent_rel = '0;
    logic        ent_last = 1'b0;
    logic        ent_ready;
    logic [7:0]  cur_col;
    logic        acc_clear = 1'b0;
    logic [5:0]  rd_row = '0;
    logic [31:0] rd_data;

    spmac_pe u_spmac_pe (
        .clk(clk), .rst_n(rst_n),
        .cb_we(cb_we), .cb_addr(cb_addr), .cb_wdata(cb_wdata),
        .act_valid(act_valid), .act_value(act_value), .act_col(act_col),
        .act_full(act_full),
        .ent_valid(ent_valid), .ent_code(ent_code), .ent_rel(ent_rel),
        .ent_last(ent_last), .ent_ready(ent_ready), .cur_col(cur_col),
        .acc_clear(acc_clear), .rd_row(rd_row), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    // reference state
    logic signed [31:0] ref_acc [ROWS];
    logic signed [15:0] ref_cb  [16];
    logic signed [15:0] mq_val  [16];
    logic [7:0]         mq_col  [16];
    int mq_head = 0, mq_tail = 0, mq_cnt = 0;
    int row_base = 0;

    function automatic logic signed [31:0] mul_ref(input logic signed [15:0] w,
                                                   input logic signed [15:0] a);
        logic signed [31:0] p;
        p = w * a;
        return p;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic cb_write(input int a, input logic signed [15:0] v);
        @(negedge clk);
        cb_we = 1'b1; cb_addr = 4'(a); cb_wdata = v;
        @(posedge clk);
        #1 cb_we = 1'b0;
        ref_cb[a] = v;
    endtask

    // offer one activation; model keeps it only if queue not full
    task automatic push_act(input logic signed [15:0] v, input logic [7:0] c);
        @(negedge clk);
        act_valid = 1'b1; act_value = v; act_col = c;
        @(posedge clk);
        if (mq_cnt < 8) begin
            mq_val[mq_tail] = v; mq_col[mq_tail] = c;
            mq_tail = (mq_tail + 1) % 16; mq_cnt++;
        end
        #1 act_valid = 1'b0;
    endtask

    task automatic feed(input int code, input int rel, input bit last,
                        input bit clr, input bit first);
        int guard;
        @(negedge clk);
        guard = 0;
        while (!ent_ready && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        if (first) check("R3 cur_col", 32'(cur_col), 32'(mq_col[mq_head]));
        ent_valid = 1'b1; ent_code = 4'(code); ent_rel = 4'(rel);
        ent_last = last; acc_clear = clr;
        @(posedge clk);
        begin
            int row;
            row = row_base + rel;
            if (clr) begin
                for (int i = 0; i < ROWS; i++) ref_acc[i] = '0;
            end else if (row < ROWS) begin
                ref_acc[row] = ref_acc[row] + mul_ref(ref_cb[code], mq_val[mq_head]);
            end
            row_base = row + 1;
            if (last) begin
                row_base = 0;
                mq_head = (mq_head + 1) % 16;
                mq_cnt--;
            end
        end
        #1;
        ent_valid = 1'b0; ent_last = 1'b0; acc_clear = 1'b0;
    endtask

    task automatic read_all(input string req);
        for (int r = 0; r < ROWS; r++) begin
            @(negedge clk);
            rd_row = 6'(r);
            #1 check(req, rd_data, ref_acc[r]);
        end
    endtask

    task automatic random_column();
        int n;
        n = 1 + int'($urandom_range(0, 6));
        for (int k = 0; k < n; k++) begin
            feed(int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
                 (k == n - 1), 1'b0, (k == 0));
        end
    endtask

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'h00C0FFEE);
        for (int i = 0; i < ROWS; i++) ref_acc[i] = '0;
        for (int i = 0; i < 16; i++) ref_cb[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R9: reset state
        @(negedge clk);
        check("R9 act_full", 32'(act_full), 32'd0);
        check("R9 ent_ready", 32'(ent_ready), 32'd0);
        read_all("R9 acc zero");

        // R10 START timing, R9 empty codebook, R11 zero weight advances row
        @(negedge clk);
        act_valid = 1'b1; act_value = 16'sd7; act_col = 8'd3;
        @(posedge clk);
        mq_val[mq_tail] = 16'sd7; mq_col[mq_tail] = 8'd3;
        mq_tail = (mq_tail + 1) % 16; mq_cnt++;
        #1 act_valid = 1'b0;
        @(negedge clk);
        check("R10 ready low before START", 32'(ent_ready), 32'd0);
        @(negedge clk);
        check("R10 ready after START", 32'(ent_ready), 32'd1);
        feed(9, 2, 1'b0, 1'b0, 1'b1);   // code 9 still 0 after reset: R9, R11
        read_all("R9 codebook zero");
        cb_write(1, 16'sd5);
        feed(1, 0, 1'b1, 1'b0, 1'b0);   // row 3: R11 filler advanced the count
        @(negedge clk);
        rd_row = 6'd3;
        #1 check("R11 row after filler", rd_data, 32'd35);
        check("R10 FINISH ready low", 32'(ent_ready), 32'd0);

        // R1: codebook load
        for (int i = 0; i < 16; i++) begin
            cb_write(i, 16'($signed(int'($urandom_range(0, 65535)))));
        end
        cb_write(0, 16'sd0);

        // R5 directed: rows 1, 2, 5 ; R6 restart
        push_act(16'sd2, 8'd10);
        push_act(-16'sd3, 8'd11);
        feed(4, 1, 1'b0, 1'b0, 1'b1);
        feed(4, 0, 1'b0, 1'b0, 1'b0);
        feed(4, 2, 1'b1, 1'b0, 1'b0);
        feed(6, 0, 1'b1, 1'b0, 1'b1);   // R6: next activation starts at row 0
        read_all("R5 R6 running row");

        // R7: rows 15,31,47,63 kept; 79 and later dropped
        push_act(16'sd1, 8'd20);
        for (int k = 0; k < 4; k++) feed(2, 15, 1'b0, 1'b0, (k == 0));
        feed(2, 15, 1'b0, 1'b0, 1'b0);
        feed(3, 0, 1'b1, 1'b0, 1'b0);
        read_all("R7 out of range");

        // R2: fill queue; ninth offer dropped
        for (int k = 0; k < 9; k++) begin
            push_act(16'(k + 1), 8'(40 + k));
            if (k == 6) check("R2 not full at 7", 32'(act_full), 32'd0);
        end
        @(negedge clk);
        check("R2 full at 8", 32'(act_full), 32'd1);
        for (int k = 0; k < 8; k++) begin
            feed(5, k, 1'b1, 1'b0, 1'b1);  // R3 order via cur_col
            if (k == 0) begin
                @(negedge clk);
                check("R2 full drops after pop", 32'(act_full), 32'd0);
            end
        end
        @(negedge clk);
        check("R2 ninth dropped, idle", 32'(ent_ready), 32'd0);
        read_all("R3 R4 queued columns");

        // R8: clear wins over a same-cycle entry
        push_act(16'sd9, 8'd60);
        feed(5, 0, 1'b0, 1'b1, 1'b1);
        feed(5, 1, 1'b1, 1'b0, 1'b0);
        read_all("R8 clear priority");

        // R4 wrap: three products of 2^30 into row 0
        cb_write(7, -16'sd32768);
        for (int k = 0; k < 3; k++) begin
            push_act(-16'sd32768, 8'(70 + k));
            feed(7, 0, 1'b1, 1'b0, 1'b1);
        end
        @(negedge clk);
        rd_row = 6'd0;
        #1 check("R4 wrap", rd_data, ref_acc[0]);

        // random phase: R1 R3 R4 R5 R6 R7 R11
        for (int rnd = 0; rnd < 12; rnd++) begin
            int n;
            if (rnd == 6) cb_write(int'($urandom_range(1, 15)), 16'($urandom_range(0, 65535)));
            n = 1 + int'($urandom_range(0, 7));
            for (int k = 0; k < n; k++) begin
                push_act(16'($urandom_range(1, 65535)), 8'($urandom_range(0, 255)));
            end
            for (int k = 0; k < n; k++) random_column();
            read_all("R4 R5 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule